// File: doc/BRIEF.md
# I2C Slave with Register Interface

This block is the target side of an I2C bus, attached to a small on-chip register bus. It brings the SCL and SDA lines into the system clock domain and finds START and STOP conditions on them. It compares the first byte of each transfer against a programmable own address, using either 7-bit or 10-bit addressing. Optionally it also answers the general call address. When it is addressed it acknowledges. It then either collects written bytes into a readable data buffer or shifts out a byte that firmware has placed in the data register.

Reception is double-buffered. A finished byte is copied out of the shift register into the data buffer, so the next byte can arrive while firmware has not yet read the buffer. Transmission has a single buffer. A register-bus write to the data register loads the data buffer and the shift register in the same clock. An interrupt flag rises at the end of every byte the block takes part in, and software clears it through the status register.

Top module: `i2c_slv_regs`

Register map (`reg_addr`):
- 0 = data
- 1 = own address low byte
- 2 = control
- 3 = status

Control bits:
- bit 0: 10-bit mode
- bit 1: general call enable
- bits 3:2: upper two bits of a 10-bit address

## Requirements
- R1: After reset, the status register reads 0x00, `sda_pull` is 0 and `irq` is 0.
- R2: A START (SDA falls while SCL is high) sets status bit 3 and clears status bit 4. A STOP (SDA rises while SCL is high) sets bit 4 and clears bit 3. Each STOP also clears status bit 5 (addressed).
- R3: In 7-bit mode, a first byte whose upper seven bits equal own address bits 6:0 is acknowledged: SDA is held low during the ninth clock, and status bit 5 is set. Any other first byte is not acknowledged, does not raise `irq` and leaves the data buffer untouched.
- R4: A written data byte to an addressed slave is acknowledged. It is copied into the data register, sets status bit 0 (buffer full) and raises `irq`. A register read of the data register clears status bit 0.
- R5: When a data byte completes while status bit 0 is still set, the byte is not acknowledged, status bit 6 (overflow) is set and the data register keeps its old value.
- R6: With control bit 1 set, the first byte 0x00 is acknowledged and sets status bit 2. With control bit 1 clear, 0x00 is not acknowledged.
- R7: In 10-bit mode the header byte `11110` + control bits 3:2 + `0` is acknowledged. A following byte that equals the own address low byte is then acknowledged and addresses the slave; any other following byte is not acknowledged.
- R8: After a 10-bit write addressing, a repeated START with header byte `11110` + control bits 3:2 + `1` is acknowledged and starts a read. Without a preceding 10-bit addressing since the last STOP, the same header is not acknowledged.
- R9: Writing the data register loads the shift register and the data buffer in the same clock, so a read of the data register returns the written value. In a read transfer the slave drives that byte MSB first and sets status bit 1 while transmitting. A master acknowledge continues with the currently loaded byte; a master NACK releases SDA.
- R10: A register write to the status register changes only bits 7 (interrupt flag) and 6 (overflow). Bits 5:0 follow bus state only.
- R11: Output `irq` equals status bit 7. It is set by every acknowledged address match and by every byte-end event of a data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 = drive SDA low (open drain) |
| irq | output | 1 | Interrupt flag |

## Verification
The bench goes after the following corner cases:
- A second byte arriving on a full buffer. A design that overwrote the buffer, or still acknowledged, would lose data without any sign.
- The two-stage 10-bit addressing, including a read header with no prior write addressing. A design that skipped the armed check would answer reads meant for other devices.
- General call with its enable both on and off, and near-miss addresses from constrained-random traffic. Either mistake shows up as a wrong ninth-clock level.
- The transmit path with a byte loaded during the acknowledge clock, followed by master ACK and then NACK. A shift one bit off, or SDA held after the NACK, corrupts the read-back byte or jams the bus.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

    localparam int BYTE_W   = 8;
    localparam int REG_AW   = 2;
    localparam int CTRL_W   = 4;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    localparam logic [REG_AW-1:0] RA_DATA = 2'd0;
    localparam logic [REG_AW-1:0] RA_OWN  = 2'd1;
    localparam logic [REG_AW-1:0] RA_CTRL = 2'd2;
    localparam logic [REG_AW-1:0] RA_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR2,
        ST_RX,
        ST_TX,
        ST_MACK
    } bus_st_e;

    typedef struct packed {
        bus_st_e               st;
        logic [BITCNT_W-1:0]   cnt;
        logic                  in_ack;
        logic                  mack;
        logic                  pull;
        logic [BYTE_W-1:0]     sh;
        logic [BYTE_W-1:0]     rbuf;
        logic                  full;
        logic                  ovf;
        logic                  irq;
        logic                  start_f;
        logic                  stop_f;
        logic                  addrd;
        logic                  gc_hit;
        logic                  ten_armed;
        logic [BYTE_W-1:0]     own;
        logic [CTRL_W-1:0]     ctrl;
    } slv_regs_t;

endpackage

// File: rtl/i2c_slv_line_sync.sv
module i2c_slv_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [STAGES-1:0] scl_sr_q, sda_sr_q;
    logic              scl_p_q, sda_p_q;

    // Idle bus is high: reset to ones so no false edge appears after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q <= '1;
            sda_sr_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_sr_q <= {scl_sr_q[STAGES-2:0], scl_in};
            sda_sr_q <= {sda_sr_q[STAGES-2:0], sda_in};
            scl_p_q  <= scl_sr_q[STAGES-1];
            sda_p_q  <= sda_sr_q[STAGES-1];
        end
    end

    always_comb begin
        scl_lvl  = scl_sr_q[STAGES-1];
        sda_lvl  = sda_sr_q[STAGES-1];
        scl_rise = scl_lvl && !scl_p_q;
        scl_fall = !scl_lvl && scl_p_q;
        start_ev = scl_lvl && scl_p_q && sda_p_q && !sda_lvl;
        stop_ev  = scl_lvl && scl_p_q && !sda_p_q && sda_lvl;
    end
endmodule

// File: rtl/i2c_slv_addr_cmp.sv
module i2c_slv_addr_cmp
    import i2c_slv_pkg::*;
(
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] own_lo,
    input  logic [1:0]        own_hi,
    input  logic              ten_bit,
    input  logic              gc_en,
    output logic              hit7,
    output logic              hdr10,
    output logic              lo10,
    output logic              hit_gc
);
    always_comb begin
        hit7   = !ten_bit && (rx_byte[BYTE_W-1:1] == own_lo[BYTE_W-2:0]);
        hdr10  = ten_bit && (rx_byte[BYTE_W-1:1] == {5'b11110, own_hi});
        lo10   = ten_bit && (rx_byte == own_lo);
        hit_gc = gc_en && (rx_byte == '0);
    end
endmodule

// File: rtl/i2c_slv_regs.sv
module i2c_slv_regs
    import i2c_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic              irq
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);

    slv_regs_t q, d;
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic hit7, hdr10, lo10, hit_gc;
    logic dir_rd;

    i2c_slv_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    i2c_slv_addr_cmp cmp_i (
        .rx_byte(q.sh), .own_lo(q.own), .own_hi(q.ctrl[3:2]),
        .ten_bit(q.ctrl[0]), .gc_en(q.ctrl[1]),
        .hit7(hit7), .hdr10(hdr10), .lo10(lo10), .hit_gc(hit_gc)
    );

    always_comb begin
        d = q;
        // register bus side
        if (reg_wr) begin
            case (reg_addr)
                RA_DATA: begin d.sh = reg_wdata; d.rbuf = reg_wdata; end
                RA_OWN:  d.own  = reg_wdata;
                RA_CTRL: d.ctrl = reg_wdata[CTRL_W-1:0];
                default: begin d.ovf = reg_wdata[6]; d.irq = reg_wdata[7]; end
            endcase
        end
        if (reg_rd && reg_addr == RA_DATA) d.full = 1'b0;

        // bus side
        if (start_ev) begin
            d.st = ST_ADDR; d.cnt = '0; d.in_ack = 1'b0; d.pull = 1'b0;
            d.start_f = 1'b1; d.stop_f = 1'b0; d.addrd = 1'b0; d.gc_hit = 1'b0;
        end else if (stop_ev) begin
            d.st = ST_IDLE; d.in_ack = 1'b0; d.pull = 1'b0; d.ten_armed = 1'b0;
            d.stop_f = 1'b1; d.start_f = 1'b0; d.addrd = 1'b0; d.gc_hit = 1'b0;
        end else if (q.st != ST_IDLE) begin
            if (scl_rise) begin
                if (q.in_ack) begin
                    if (q.st == ST_MACK) d.mack = !sda_lvl;
                end else if (q.cnt != LAST_BIT) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.st != ST_TX) d.sh = {q.sh[BYTE_W-2:0], sda_lvl};
                end
            end
            if (scl_fall) begin
                if (q.in_ack) begin
                    // end of ninth clock
                    d.in_ack = 1'b0; d.pull = 1'b0; d.cnt = '0;
                    if (q.st == ST_TX) begin
                        d.pull = !q.sh[BYTE_W-1];
                    end else if (q.st == ST_MACK) begin
                        if (q.mack) begin
                            d.st = ST_TX; d.pull = !q.sh[BYTE_W-1];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end else if (q.cnt == LAST_BIT) begin
                    // byte complete: decide on the ninth clock
                    d.in_ack = 1'b1;
                    case (q.st)
                        ST_ADDR: begin
                            if (hit_gc) begin
                                d.pull = 1'b1; d.st = ST_RX; d.gc_hit = 1'b1;
                                d.addrd = 1'b1; d.irq = 1'b1;
                            end else if (hit7) begin
                                d.pull = 1'b1; d.addrd = 1'b1; d.irq = 1'b1;
                                d.st = q.sh[0] ? ST_TX : ST_RX;
                            end else if (hdr10 && !q.sh[0]) begin
                                d.pull = 1'b1; d.st = ST_ADDR2;
                            end else if (hdr10 && q.ten_armed) begin
                                d.pull = 1'b1; d.st = ST_TX; d.addrd = 1'b1; d.irq = 1'b1;
                            end else begin
                                d.st = ST_IDLE; d.in_ack = 1'b0;
                            end
                        end
                        ST_ADDR2: begin
                            if (lo10) begin
                                d.pull = 1'b1; d.st = ST_RX; d.ten_armed = 1'b1;
                                d.addrd = 1'b1; d.irq = 1'b1;
                            end else begin
                                d.st = ST_IDLE; d.in_ack = 1'b0;
                            end
                        end
                        ST_RX: begin
                            d.irq = 1'b1;
                            if (q.full) begin
                                d.ovf = 1'b1;
                            end else begin
                                d.rbuf = q.sh; d.full = 1'b1; d.pull = 1'b1;
                            end
                        end
                        default: begin
                            // transmitted byte done: release for master ack
                            d.pull = 1'b0; d.st = ST_MACK; d.irq = 1'b1;
                        end
                    endcase
                end else if (q.st == ST_TX && q.cnt != '0) begin
                    d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                    d.pull = !q.sh[BYTE_W-2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        dir_rd = (q.st == ST_TX) || (q.st == ST_MACK);
        case (reg_addr)
            RA_DATA: reg_rdata = q.rbuf;
            RA_OWN:  reg_rdata = q.own;
            RA_CTRL: reg_rdata = {{(BYTE_W-CTRL_W){1'b0}}, q.ctrl};
            default: reg_rdata = {q.irq, q.ovf, q.addrd, q.stop_f, q.start_f,
                                  q.gc_hit, dir_rd, q.full};
        endcase
        sda_pull = q.pull;
        irq      = q.irq;
    end

    // ---------------- assertions ----------------
    p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.start_f && q.stop_f));

    p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.pull);

    p_full_raises_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> q.irq);

    p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && !(reg_wr && reg_addr == RA_DATA)) |=> $stable(q.rbuf));

    p_overflow_nacks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.ovf) && !$past(reg_wr && reg_addr == RA_STAT)) |-> (q.full && !q.pull));

    p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pull != $past(q.pull)) |-> (!$past(scl_lvl) || $past(start_ev || stop_ev)));

    p_match_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.addrd) |-> q.irq);
endmodule

// File: tb/i2c_slv_regs_tb.sv
`timescale 1ns/1ps
module i2c_slv_regs_tb_top;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_pull, irq;
    logic       sda_line;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_slv_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_in(scl_m), .sda_in(sda_line), .sda_pull(sda_pull), .irq(irq)
    );

    function automatic logic exp_ack7(input logic [6:0] a, input logic [6:0] own);
        return a == own;
    endfunction

    function automatic logic [7:0] hdr10(input logic [1:0] hi, input logic rw);
        return {5'b11110, hi, rw};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic i2c_start();
        if (!scl_m) begin
            idle(Q); sda_m = 1'b1; idle(Q); scl_m = 1'b1; idle(Q);
        end
        sda_m = 1'b0; idle(2*Q); scl_m = 1'b0;
    endtask

    task automatic i2c_stop();
        idle(Q); sda_m = 1'b0; idle(Q); scl_m = 1'b1; idle(Q); sda_m = 1'b1; idle(2*Q);
    endtask

    task automatic write_byte(input logic [7:0] b, input logic load, input logic [7:0] nxt,
                              output logic acked);
        for (int i = 7; i >= 0; i--) begin
            idle(Q); sda_m = b[i]; idle(Q); scl_m = 1'b1; idle(2*Q); scl_m = 1'b0;
        end
        idle(Q); sda_m = 1'b1;
        if (load) reg_write(2'd0, nxt);
        idle(Q); scl_m = 1'b1; idle(Q);
        acked = !sda_line;
        idle(Q); scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic ack, input logic load, input logic [7:0] nxt,
                             output logic [7:0] got);
        for (int i = 7; i >= 0; i--) begin
            idle(Q); sda_m = 1'b1; idle(Q); scl_m = 1'b1; idle(Q);
            got[i] = sda_line;
            idle(Q); scl_m = 1'b0;
        end
        idle(Q);
        if (load) reg_write(2'd0, nxt);
        sda_m = !ack; idle(Q); scl_m = 1'b1; idle(2*Q); scl_m = 1'b0;
        idle(Q); sda_m = 1'b1;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [7:0] v, got;
        logic       a;
        void'($urandom(32'd7321));
        idle(4); rst_n = 1'b1; idle(4);

        // R1 reset state
        reg_read(2'd3, v);
        chk("R1 status after reset", v, 8'h00);
        chk("R1 sda_pull after reset", sda_pull, 1'b0);
        chk("R1 irq after reset", irq, 1'b0);

        reg_write(2'd1, 8'h5A);
        reg_write(2'd2, 8'h00);

        // R2, R3, R11 addressing
        i2c_start(); idle(Q);
        reg_read(2'd3, v);
        chk("R2 start flag set, stop clear", v[4:3], 2'b01);
        write_byte({7'h5A, 1'b0}, 1'b0, 8'h00, a);
        chk("R3 own address acked", a, 1'b1);
        reg_read(2'd3, v);
        chk("R3 addressed bit", v[5], 1'b1);
        chk("R11 irq on match", irq, 1'b1);
        reg_write(2'd3, 8'h00);
        chk("R10 irq cleared by status write", irq, 1'b0);
        reg_read(2'd3, v);
        chk("R10 low bits unaffected by write", v[5:0], 6'b101000);

        // R4 receive
        write_byte(8'hC3, 1'b0, 8'h00, a);
        chk("R4 data acked", a, 1'b1);
        reg_read(2'd3, v);
        chk("R4 buffer full", v[0], 1'b1);
        chk("R11 irq after data byte", irq, 1'b1);
        reg_read(2'd0, v);
        chk("R4 buffer value", v, 8'hC3);
        reg_read(2'd3, v);
        chk("R4 read clears full", v[0], 1'b0);

        // R5 overflow
        write_byte(8'h22, 1'b0, 8'h00, a);
        chk("R5 first byte acked", a, 1'b1);
        write_byte(8'h33, 1'b0, 8'h00, a);
        chk("R5 byte on full buffer nacked", a, 1'b0);
        reg_read(2'd3, v);
        chk("R5 overflow set", v[6], 1'b1);
        i2c_stop();
        reg_read(2'd3, v);
        chk("R2 stop flag set, start clear, unaddressed", v[5:3], 3'b010);
        reg_read(2'd0, v);
        chk("R5 buffer kept old byte", v, 8'h22);
        reg_write(2'd3, 8'h00);

        // R3 mismatch ignored
        i2c_start();
        write_byte({7'h5B, 1'b0}, 1'b0, 8'h00, a);
        chk("R3 foreign address nacked", a, 1'b0);
        write_byte(8'h99, 1'b0, 8'h00, a);
        chk("R3 foreign data ignored", a, 1'b0);
        i2c_stop();
        chk("R3 no irq on mismatch", irq, 1'b0);
        reg_read(2'd3, v);
        chk("R3 buffer not filled", v[0], 1'b0);

        // R6 general call
        i2c_start();
        write_byte(8'h00, 1'b0, 8'h00, a);
        chk("R6 general call ignored when disabled", a, 1'b0);
        i2c_stop();
        reg_write(2'd2, 8'h02);
        i2c_start();
        write_byte(8'h00, 1'b0, 8'h00, a);
        chk("R6 general call acked when enabled", a, 1'b1);
        reg_read(2'd3, v);
        chk("R6 general call status", v[2], 1'b1);
        write_byte(8'h77, 1'b0, 8'h00, a);
        reg_read(2'd0, v);
        chk("R6 general call data", v, 8'h77);
        i2c_stop();
        reg_write(2'd3, 8'h00);

        // R7 / R8 10-bit
        reg_write(2'd2, 8'h09);
        i2c_start();
        write_byte(hdr10(2'b10, 1'b0), 1'b0, 8'h00, a);
        chk("R7 10-bit header acked", a, 1'b1);
        write_byte(8'h5A, 1'b0, 8'h00, a);
        chk("R7 10-bit low byte acked", a, 1'b1);
        write_byte(8'h9E, 1'b0, 8'h00, a);
        chk("R7 10-bit data acked", a, 1'b1);
        reg_read(2'd0, v);
        chk("R7 10-bit data value", v, 8'h9E);
        i2c_start();
        write_byte(hdr10(2'b10, 1'b1), 1'b1, 8'hA5, a);
        chk("R8 10-bit read header acked", a, 1'b1);
        reg_read(2'd3, v);
        chk("R9 transmit direction bit", v[1], 1'b1);
        reg_read(2'd0, v);
        chk("R9 data register shows loaded byte", v, 8'hA5);
        read_byte(1'b0, 1'b0, 8'h00, got);
        chk("R8 10-bit read data", got, 8'hA5);
        i2c_stop();
        i2c_start();
        write_byte(hdr10(2'b10, 1'b0), 1'b0, 8'h00, a);
        write_byte(8'h5B, 1'b0, 8'h00, a);
        chk("R7 wrong low byte nacked", a, 1'b0);
        i2c_stop();
        i2c_start();
        write_byte(hdr10(2'b10, 1'b1), 1'b0, 8'h00, a);
        chk("R8 read header without addressing nacked", a, 1'b0);
        i2c_stop();
        reg_write(2'd3, 8'h00);

        // R9 7-bit transmit, master ack then nack
        reg_write(2'd2, 8'h00);
        i2c_start();
        write_byte({7'h5A, 1'b1}, 1'b1, 8'h3C, a);
        chk("R9 read address acked", a, 1'b1);
        read_byte(1'b1, 1'b1, 8'hE1, got);
        chk("R9 first transmitted byte", got, 8'h3C);
        read_byte(1'b0, 1'b0, 8'h00, got);
        chk("R9 second transmitted byte", got, 8'hE1);
        chk("R9 SDA released after master nack", sda_pull, 1'b0);
        i2c_stop();
        reg_write(2'd3, 8'hC0);
        reg_read(2'd3, v);
        chk("R10 top bits writable, low bits kept", v, 8'hD0);
        chk("R11 irq follows status bit 7", irq, 1'b1);
        reg_write(2'd3, 8'h00);

        // constrained random 7-bit writes
        for (int it = 0; it < 16; it++) begin
            logic [6:0] own, adr;
            logic [7:0] dat;
            logic       ex;
            own = 7'($urandom_range(1, 127));
            adr = ($urandom_range(0, 1) == 1) ? own : 7'($urandom_range(1, 127));
            dat = 8'($urandom);
            ex  = exp_ack7(adr, own);
            reg_write(2'd1, {1'b0, own});
            i2c_start();
            write_byte({adr, 1'b0}, 1'b0, 8'h00, a);
            chk("R3 random address ack", a, ex);
            if (ex) begin
                write_byte(dat, 1'b0, 8'h00, a);
                chk("R4 random data ack", a, 1'b1);
            end
            i2c_stop();
            if (ex) begin
                reg_read(2'd0, v);
                chk("R4 random data value", v, dat);
            end else begin
                chk("R3 random mismatch no irq", irq, 1'b0);
            end
            reg_write(2'd3, 8'h00);
        end

        done = 1'b1;
        report();
    end
endmodule